// File: doc/BRIEF.md
# Selectable Infrared Carrier Generator

This block turns the system clock into the modulated drive for an infrared transmit pin. A small select register picks one of six pulse shapes, given as period and high time in system clocks, or a plain unmodulated level. A one-bit data register turns transmission on and off. While the data bit is set, the block repeats the chosen pulse shape. While it is clear, the output stays inactive.

The pin it models is open-drain. `ir_sink_o` high means the pin sinks current and the LED is lit. `ir_oe_o` low means the pin floats, which is the state it takes in stop mode. Software writes the select code first and then sets the data bit.

The phase counter restarts at the start of a high phase each time the data bit rises, so the first pulse is always whole. A new select code written while a carrier runs waits for the current period to end before it takes effect.

Top module: `ir_carrier_gen`

## Requirements
- R1: During and right after reset, `ir_sink_o` is 0 and `ir_oe_o` is 1. The data bit resets to 0 and the select code resets to 000.
- R2: Select codes 000, 001 and 010 give a period of 12 clocks, with the output high for the first 6, 4 and 3 clocks of each period respectively.
- R3: Select code 011 gives a period of 8 clocks with 4 high. Code 100 gives a period of 8 clocks with 2 high.
- R4: Select code 101 gives a period of 11 clocks with the first 4 high.
- R5: Select codes 110 and 111 produce no carrier: outside stop mode, `ir_sink_o` equals the data bit.
- R6: A data write loads bit 3 of `dat_wdata` into the data bit, and the other bits have no effect. With the data bit at 0, `ir_sink_o` is 0.
- R7: When a data write changes the data bit from 0 to 1, the output is high in the first cycle after that write. A full high phase follows.
- R8: A select write made while a carrier runs changes the shape only at the next period boundary, so the period in progress completes unchanged.
- R9: While `stop_i` is 1, `ir_oe_o` and `ir_sink_o` are 0 and the phase is held at the start of a high phase. After `stop_i` falls, the output starts with a full pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_we | input | 1 | Write strobe for the carrier select register |
| sel_wdata | input | 3 | Carrier select code |
| dat_we | input | 1 | Write strobe for the transmit data bit |
| dat_wdata | input | 4 | Written value; bit 3 is the data bit |
| stop_i | input | 1 | Stop mode: pin floats and phase is held |
| ir_sink_o | output | 1 | 1 = pin sinks current (LED lit) |
| ir_oe_o | output | 1 | 0 = pin in high-impedance state |

## Verification
The assertions take for granted that a select code is written at least one clock before the data bit is raised. They also assume `stop_i` is a level held for whole clocks rather than a glitch. The stimulus keeps within this: every select write completes on its own clock edge before any data write, and stop is changed only between edges. Under those conditions, a change of the active shape is expected only when the phase counter returns to zero, and the counter is expected never to reach the period.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

    localparam int CAR_CNT_W = 4;
    localparam int CAR_SEL_W = 3;

    typedef logic [CAR_CNT_W-1:0] car_cnt_t;
    typedef logic [CAR_SEL_W-1:0] car_sel_t;

    // select codes; the encoding is fixed by the software view
    typedef enum logic [CAR_SEL_W-1:0] {
        SEL_P12_H6 = 3'b000,
        SEL_P12_H4 = 3'b001,
        SEL_P12_H3 = 3'b010,
        SEL_P8_H4  = 3'b011,
        SEL_P8_H2  = 3'b100,
        SEL_P11_H4 = 3'b101,
        SEL_OFF_A  = 3'b110,
        SEL_OFF_B  = 3'b111
    } car_sel_e;

    typedef struct packed {
        car_cnt_t period;
        car_cnt_t high_len;
        logic     bypass;
    } car_shape_t;

    // pulse shape per select code; bypass codes use a one-clock period
    function automatic car_shape_t car_shape(input car_sel_t code);
        car_shape_t s;
        case (car_sel_e'(code))
            SEL_P12_H6: s = '{period: car_cnt_t'(12), high_len: car_cnt_t'(6), bypass: 1'b0};
            SEL_P12_H4: s = '{period: car_cnt_t'(12), high_len: car_cnt_t'(4), bypass: 1'b0};
            SEL_P12_H3: s = '{period: car_cnt_t'(12), high_len: car_cnt_t'(3), bypass: 1'b0};
            SEL_P8_H4:  s = '{period: car_cnt_t'(8),  high_len: car_cnt_t'(4), bypass: 1'b0};
            SEL_P8_H2:  s = '{period: car_cnt_t'(8),  high_len: car_cnt_t'(2), bypass: 1'b0};
            SEL_P11_H4: s = '{period: car_cnt_t'(11), high_len: car_cnt_t'(4), bypass: 1'b0};
            default:    s = '{period: car_cnt_t'(1),  high_len: car_cnt_t'(1), bypass: 1'b1};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ir_car_regs.sv
module ir_car_regs
    import ir_carrier_pkg::*;
#(
    parameter int DATA_W   = 4,
    parameter int DATA_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  car_sel_t          sel_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    output car_sel_t          sel_next,
    output logic              dat_q,
    output logic              restart
);

    car_sel_t sel_q;
    logic     dat_next;

    assign sel_next = sel_we ? sel_wdata : sel_q;
    assign dat_next = dat_we ? dat_wdata[DATA_BIT] : dat_q;
    assign restart  = dat_next & ~dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            dat_q <= 1'b0;
        end else begin
            sel_q <= sel_next;
            dat_q <= dat_next;
        end
    end

    // R6: only the selected bit of a data write reaches the data register
    assert_data_bit_R6: assert property (@(posedge clk) disable iff (rst)
        dat_we |=> (dat_q == $past(dat_wdata[DATA_BIT])));

endmodule

// File: rtl/ir_car_phase.sv
module ir_car_phase
    import ir_carrier_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_i,
    input  logic       restart,
    input  car_sel_t   sel_load,
    output car_cnt_t   cnt_q,
    output car_sel_t   act_q,
    output logic       carrier_hi,
    output logic       bypass
);

    car_shape_t shp;
    logic       at_end;

    assign shp        = car_shape(act_q);
    assign at_end     = (cnt_q == car_cnt_t'(shp.period - car_cnt_t'(1)));
    assign carrier_hi = (cnt_q < shp.high_len);
    assign bypass     = shp.bypass;

    // shape is taken over only at a period start, restart or in stop
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            act_q <= '0;
        end else if (stop_i || restart || at_end) begin
            cnt_q <= '0;
            act_q <= sel_load;
        end else begin
            cnt_q <= cnt_q + car_cnt_t'(1);
        end
    end

    // R2: the phase never reaches the period of the active shape
    assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q < car_shape(act_q).period);

    // R8: the active shape changes only when a new period begins
    assert_sel_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(act_q) |-> (cnt_q == '0));

endmodule

// File: rtl/ir_car_drive.sv
module ir_car_drive (
    input  logic stop_i,
    input  logic dat_q,
    input  logic carrier_hi,
    input  logic bypass,
    output logic ir_sink_o,
    output logic ir_oe_o
);

    logic lit;

    assign lit       = dat_q & (bypass | carrier_hi);
    assign ir_sink_o = lit & ~stop_i;
    assign ir_oe_o   = ~stop_i;

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_carrier_pkg::*;
#(
    parameter int DATA_W   = 4,
    parameter int DATA_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we,
    input  logic [2:0]        sel_wdata,
    input  logic              dat_we,
    input  logic [DATA_W-1:0] dat_wdata,
    input  logic              stop_i,
    output logic              ir_sink_o,
    output logic              ir_oe_o
);

    car_sel_t sel_next;
    car_sel_t act_q;
    car_cnt_t cnt_q;
    logic     dat_q;
    logic     restart;
    logic     carrier_hi;
    logic     bypass;

    ir_car_regs #(.DATA_W(DATA_W), .DATA_BIT(DATA_BIT)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .sel_next  (sel_next),
        .dat_q     (dat_q),
        .restart   (restart)
    );

    ir_car_phase phase_i (
        .clk        (clk),
        .rst        (rst),
        .stop_i     (stop_i),
        .restart    (restart),
        .sel_load   (sel_next),
        .cnt_q      (cnt_q),
        .act_q      (act_q),
        .carrier_hi (carrier_hi),
        .bypass     (bypass)
    );

    ir_car_drive drive_i (
        .stop_i     (stop_i),
        .dat_q      (dat_q),
        .carrier_hi (carrier_hi),
        .bypass     (bypass),
        .ir_sink_o  (ir_sink_o),
        .ir_oe_o    (ir_oe_o)
    );

    // R7: a rising data bit always finds the phase at the start of a pulse
    assert_restart_phase_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_q) |-> (cnt_q == '0));

    // R9: stop floats the pin and removes the drive
    assert_stop_hiz_R9: assert property (@(posedge clk) disable iff (rst)
        stop_i |-> (!ir_oe_o && !ir_sink_o));

    // R5: without a carrier the pin follows the data bit
    assert_bypass_follow_R5: assert property (@(posedge clk) disable iff (rst)
        (!stop_i && act_q[2] && act_q[1]) |-> (ir_sink_o == dat_q));

endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb_top;

    typedef struct packed {
        logic [2:0] code;
        logic [3:0] per;
        logic [3:0] hi;
        logic       byp;
    } vec_t;

    localparam vec_t VEC [0:7] = '{
        '{code: 3'd0, per: 4'd12, hi: 4'd6, byp: 1'b0},
        '{code: 3'd1, per: 4'd12, hi: 4'd4, byp: 1'b0},
        '{code: 3'd2, per: 4'd12, hi: 4'd3, byp: 1'b0},
        '{code: 3'd3, per: 4'd8,  hi: 4'd4, byp: 1'b0},
        '{code: 3'd4, per: 4'd8,  hi: 4'd2, byp: 1'b0},
        '{code: 3'd5, per: 4'd11, hi: 4'd4, byp: 1'b0},
        '{code: 3'd6, per: 4'd4,  hi: 4'd4, byp: 1'b1},
        '{code: 3'd7, per: 4'd4,  hi: 4'd4, byp: 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       sel_we;
    logic [2:0] sel_wdata;
    logic       dat_we;
    logic [3:0] dat_wdata;
    logic       stop_i;
    logic       ir_sink_o;
    logic       ir_oe_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ir_carrier_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .dat_we    (dat_we),
        .dat_wdata (dat_wdata),
        .stop_i    (stop_i),
        .ir_sink_o (ir_sink_o),
        .ir_oe_o   (ir_oe_o)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0b exp=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // each write task returns at the falling edge after the write edge
    task automatic wr_sel(input logic [2:0] v);
        sel_wdata = v;
        sel_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sel_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [3:0] v);
        dat_wdata = v;
        dat_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    function automatic logic pat(input int k, input int per, input int hi);
        return ((k % per) < hi);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        string tag;
        rst = 1'b1; sel_we = 1'b0; sel_wdata = '0;
        dat_we = 1'b0; dat_wdata = '0; stop_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 sink in reset", ir_sink_o, 1'b0);
        chk("R1 oe in reset", ir_oe_o, 1'b1);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sink after reset", ir_sink_o, 1'b0);
        chk("R1 oe after reset", ir_oe_o, 1'b1);

        // table walk: every select code from an idle data bit
        for (int v = 0; v < 8; v++) begin
            int n;
            if (VEC[v].byp) tag = "R5";
            else if (VEC[v].per == 4'd12) tag = "R2";
            else if (VEC[v].per == 4'd8) tag = "R3";
            else tag = "R4";
            wr_sel(VEC[v].code);
            chk({tag, " idle before data"}, ir_sink_o, 1'b0);
            wr_dat(4'b1000);
            n = VEC[v].byp ? 8 : 2 * int'(VEC[v].per);
            for (int k = 0; k < n; k++) begin
                chk({tag, " pattern"}, ir_sink_o,
                    VEC[v].byp ? 1'b1 : pat(k, int'(VEC[v].per), int'(VEC[v].hi)));
                @(negedge clk);
            end
            wr_dat(4'b0111);
            for (int k = 0; k < 3; k++) begin
                chk({tag, " off after clear"}, ir_sink_o, 1'b0);
                @(negedge clk);
            end
        end

        // R6: only bit 3 counts
        wr_sel(3'd0);
        wr_dat(4'b0111);
        for (int k = 0; k < 4; k++) begin
            chk("R6 low bits ignored", ir_sink_o, 1'b0);
            @(negedge clk);
        end
        wr_dat(4'b1000);
        chk("R6 bit3 enables", ir_sink_o, 1'b1);

        // R7: restart from the low phase gives a whole pulse
        for (int k = 0; k < 8; k++) @(negedge clk);
        chk("R7 low phase before restart", ir_sink_o, 1'b0);
        wr_dat(4'b0000);
        chk("R7 cleared", ir_sink_o, 1'b0);
        wr_dat(4'b1000);
        for (int k = 0; k < 12; k++) begin
            chk("R7 full first pulse", ir_sink_o, pat(k, 12, 6));
            @(negedge clk);
        end
        wr_dat(4'b0000);

        // R8: select change mid-period waits for the boundary
        wr_sel(3'd0);
        wr_dat(4'b1000);
        for (int k = 0; k < 28; k++) begin
            chk("R8 boundary switch", ir_sink_o,
                (k < 12) ? pat(k, 12, 6) : pat(k - 12, 8, 4));
            if (k == 1) wr_sel(3'd3);
            else @(negedge clk);
        end
        wr_dat(4'b0000);

        // R9: stop floats the pin, release restarts with a full pulse
        wr_sel(3'd0);
        wr_dat(4'b1000);
        @(negedge clk);
        @(negedge clk);
        stop_i = 1'b1;
        #1;
        for (int k = 0; k < 5; k++) begin
            chk("R9 oe in stop", ir_oe_o, 1'b0);
            chk("R9 sink in stop", ir_sink_o, 1'b0);
            @(negedge clk);
        end
        stop_i = 1'b0;
        #1;
        for (int k = 0; k < 12; k++) begin
            chk("R9 oe after stop", ir_oe_o, 1'b1);
            chk("R9 full pulse after stop", ir_sink_o, pat(k, 12, 6));
            @(negedge clk);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule